// File: doc/BRIEF.md
# Floating-Point Exception Status and Trap Unit

This block owns the exception-related fields of a 32-bit floating-point status register. Each time the arithmetic datapath retires an operation it raises a commit strobe together with five raw exception flags, an indication of whether the operation was a comparison, and an optional request for a non-IEEE trap such as an unfinished or unimplemented operation. The block checks the raised flags against the trap-enable mask held in the register. In the same cycle it tells the datapath whether the operation traps and whether the destination register may be written. On the next clock edge it updates the current-exception, accrued-exception and trap-type fields.

When a trap occurs, only the most important enabled exception is left in the current field. The accrued field is left as it was, and a numeric cause code names that exception. An operation that completes replaces the current field with everything it raised and ORs the same flags into the accrued field. A whole-register load port lets the enclosing core write the status register, including the mask. A load and a commit may arrive in the same cycle.

Top module: `fpx_status_trap`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the whole status register is cleared to zero.
- R2: Field layout: current exceptions in bits 4:0, accrued exceptions in bits 9:5, trap type in bits 16:14, trap-enable mask in bits 27:23. Within each 5-bit field, bit 4 is invalid, bit 3 overflow, bit 2 underflow, bit 1 divide-by-zero and bit 0 inexact. A load with no commit copies `ld_data_i` into all 32 bits.
- R3: A commit whose raised flags meet no enabled mask bit does three things. It replaces the current field with the raised flags, ORs them into the accrued field, and sets the trap type to 0 (none). In the same cycle `trap_o` is low and `rd_wr_en_o` is high for a non-compare operation.
- R4: A commit whose raised flags meet at least one enabled mask bit drives `trap_o` high and `rd_wr_en_o` low in the same cycle. It then sets the trap type to 1 (IEEE exception) and loads the current field with only the highest-priority enabled raised flag. The accrued field is left unchanged.
- R5: `cause_o` names the highest-priority enabled raised flag of an IEEE trap: 5 invalid, 4 overflow, 3 underflow, 2 divide-by-zero, 1 inexact. It is 0 whenever `trap_o` is low.
- R6: For a compare (`is_cmp_i` high), only the invalid flag is considered and all other raised flags are ignored. `rd_wr_en_o` is never high for a compare.
- R7: A commit with `xtrap_i` high traps regardless of flags. The trap type is loaded from `xtype_i` (2 unfinished, 3 unimplemented, 4 sequence error, 5 hardware error). The current and accrued fields are unchanged, `cause_o` is 0 and `rd_wr_en_o` is low.
- R8: Without a commit, `trap_o`, `rd_wr_en_o` and `cause_o` are low, and the register holds unless loaded. Flags, compare and trap-request inputs have no effect.
- R9: When a load and a commit coincide, the trap decision uses the mask from before the load. Fields the commit writes take the commit's values, with accrual ORed onto the loaded accrued field. Every other bit comes from `ld_data_i`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| commit_i | input | 1 | An operation retires this cycle |
| is_cmp_i | input | 1 | Retiring operation is a comparison |
| exc_flags_i | input | 5 | Raised exception flags of the retiring operation |
| xtrap_i | input | 1 | Retiring operation requests a non-IEEE trap |
| xtype_i | input | 3 | Trap-type code for a non-IEEE trap |
| ld_en_i | input | 1 | Write the whole status register |
| ld_data_i | input | 32 | Value for a status register write |
| fsr_o | output | 32 | Current status register contents |
| trap_o | output | 1 | Retiring operation traps (combinational) |
| rd_wr_en_o | output | 1 | Destination register write allowed (combinational) |
| cause_o | output | 3 | Trap cause code (combinational) |

## Verification
A register load and a commit can land in the same cycle. The load may change the trap-enable mask that the commit is being judged against. The bench provokes this by loading one mask and then issuing a load that carries the opposite mask alongside a commit, both for trapping and for non-trapping flags and for a non-IEEE trap request. It judges the result by checking that the same-cycle trap and write-enable outputs follow the old mask. It then checks that the register holds the loaded value in every bit except the commit-owned fields, and that accrual is ORed on top of the loaded accrued field.

// File: rtl/fpx_pkg.sv
`timescale 1ns/1ps
// fpx_pkg: shared widths, field positions, codes and the update record
// passed from the trap decision logic to the status register.
package fpx_pkg;

    parameter int FSR_W    = 32;   // status register width
    parameter int NFLAG    = 5;    // number of IEEE exception flags
    parameter int CEXC_LSB = 0;    // current-exception field
    parameter int AEXC_LSB = 5;    // accrued-exception field
    parameter int FTT_LSB  = 14;   // trap-type field
    parameter int FTT_W    = 3;
    parameter int TEM_LSB  = 23;   // trap-enable mask field
    parameter int CAUSE_W  = $clog2(NFLAG + 1);

    // Flag index within a 5-bit field; higher index = higher priority.
    parameter int FLG_NV = 4;
    parameter int FLG_OF = 3;
    parameter int FLG_UF = 2;
    parameter int FLG_DZ = 1;
    parameter int FLG_NX = 0;

    typedef logic [NFLAG-1:0] flags_t;

    // Only the invalid flag survives on a comparison.
    parameter flags_t CMP_KEEP = flags_t'(1) << FLG_NV;

    typedef enum logic [FTT_W-1:0] {
        FTT_NONE  = 3'd0,
        FTT_IEEE  = 3'd1,
        FTT_UNFIN = 3'd2,
        FTT_UNIMP = 3'd3,
        FTT_SEQ   = 3'd4,
        FTT_HWERR = 3'd5
    } ftt_e;

    // Field write request produced for one committing operation.
    typedef struct packed {
        logic             wr_cexc;
        flags_t           cexc;
        logic             wr_aexc;
        flags_t           aexc_or;
        logic             wr_ftt;
        logic [FTT_W-1:0] ftt;
    } fld_upd_t;

endpackage

// File: rtl/fpx_prio_pick.sv
`timescale 1ns/1ps
// fpx_prio_pick: keeps only the most significant set bit of a request
// vector and returns its position plus one as a code (0 when empty).
// Assumes the most significant bit carries the highest priority.
module fpx_prio_pick #(
    parameter int N  = 5,
    parameter int CW = $clog2(N + 1)
) (
    input  logic [N-1:0]  req_i,
    output logic [N-1:0]  hot_o,
    output logic [CW-1:0] code_o
);

    // A bit wins when no bit above it is set.
    for (genvar g = 0; g < N; g++) begin : g_hot
        if (g == N - 1) begin : g_top
            assign hot_o[g] = req_i[g];
        end else begin : g_low
            assign hot_o[g] = req_i[g] & ~(|req_i[N-1:g+1]);
        end
    end

    // Encode the winning position as index plus one.
    always_comb begin
        code_o = '0;
        for (int i = 0; i < N; i++) begin
            if (hot_o[i]) code_o = CW'(i + 1);
        end
    end

endmodule

// File: rtl/fpx_trap_decide.sv
`timescale 1ns/1ps
// fpx_trap_decide: judges one committing operation against the trap
// enable mask and produces the same-cycle trap / write-enable / cause
// outputs plus the field updates for the status register.
// Assumes the mask given is the register contents before any load.
module fpx_trap_decide
    import fpx_pkg::*;
(
    input  logic               commit_i,
    input  logic               is_cmp_i,
    input  flags_t             flags_i,
    input  flags_t             tem_i,
    input  logic               xtrap_i,
    input  logic [FTT_W-1:0]   xtype_i,
    output logic               trap_o,
    output logic               rd_wr_en_o,
    output logic [CAUSE_W-1:0] cause_o,
    output fld_upd_t           upd_o
);

    flags_t             eff;
    flags_t             enabled;
    flags_t             top_hot;
    logic [CAUSE_W-1:0] top_code;

    // Comparisons can only report the invalid condition (R6).
    always_comb begin
        eff     = is_cmp_i ? (flags_i & CMP_KEEP) : flags_i;
        enabled = eff & tem_i;
    end

    fpx_prio_pick #(
        .N  (NFLAG),
        .CW (CAUSE_W)
    ) u_pick (
        .req_i  (enabled),
        .hot_o  (top_hot),
        .code_o (top_code)
    );

    // Choose between idle, external trap, IEEE trap and completion.
    always_comb begin
        trap_o     = 1'b0;
        rd_wr_en_o = 1'b0;
        cause_o    = '0;
        upd_o      = '0;
        if (commit_i) begin
            if (xtrap_i) begin
                trap_o       = 1'b1;
                upd_o.wr_ftt = 1'b1;
                upd_o.ftt    = xtype_i;
            end else if (|enabled) begin
                trap_o        = 1'b1;
                cause_o       = top_code;
                upd_o.wr_cexc = 1'b1;
                upd_o.cexc    = top_hot;
                upd_o.wr_ftt  = 1'b1;
                upd_o.ftt     = FTT_IEEE;
            end else begin
                rd_wr_en_o    = ~is_cmp_i;
                upd_o.wr_cexc = 1'b1;
                upd_o.cexc    = eff;
                upd_o.wr_aexc = 1'b1;
                upd_o.aexc_or = eff;
                upd_o.wr_ftt  = 1'b1;
                upd_o.ftt     = FTT_NONE;
            end
        end
    end

endmodule

// File: rtl/fpx_status_reg.sv
`timescale 1ns/1ps
// fpx_status_reg: the status register itself. A whole-register load
// forms the base value; the commit's field updates are laid on top.
// Assumes synchronous active-low reset clearing every bit.
module fpx_status_reg
    import fpx_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld_en_i,
    input  logic [FSR_W-1:0] ld_data_i,
    input  fld_upd_t         upd_i,
    output logic [FSR_W-1:0] fsr_o
);

    logic [FSR_W-1:0] fsr_q;
    logic [FSR_W-1:0] fsr_d;

    // Merge load data and commit updates into the next value.
    always_comb begin
        fsr_d = ld_en_i ? ld_data_i : fsr_q;
        if (upd_i.wr_cexc) fsr_d[CEXC_LSB +: NFLAG] = upd_i.cexc;
        if (upd_i.wr_aexc) fsr_d[AEXC_LSB +: NFLAG] = fsr_d[AEXC_LSB +: NFLAG] | upd_i.aexc_or;
        if (upd_i.wr_ftt)  fsr_d[FTT_LSB +: FTT_W]  = upd_i.ftt;
    end

    // State register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) fsr_q <= '0;
        else        fsr_q <= fsr_d;
    end

    assign fsr_o = fsr_q;

endmodule

// File: rtl/fpx_status_trap.sv
`timescale 1ns/1ps
// fpx_status_trap: floating-point exception status and trap unit.
// Decides per committing operation whether it traps, reports that in
// the same cycle, and updates the exception fields of the register.
// Assumes at most one commit per cycle.
module fpx_status_trap
    import fpx_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               commit_i,
    input  logic               is_cmp_i,
    input  logic [NFLAG-1:0]   exc_flags_i,
    input  logic               xtrap_i,
    input  logic [FTT_W-1:0]   xtype_i,
    input  logic               ld_en_i,
    input  logic [FSR_W-1:0]   ld_data_i,
    output logic [FSR_W-1:0]   fsr_o,
    output logic               trap_o,
    output logic               rd_wr_en_o,
    output logic [CAUSE_W-1:0] cause_o
);

    fld_upd_t upd;
    flags_t   tem_now;

    // The mask is taken from the register before any same-cycle load (R9).
    assign tem_now = fsr_o[TEM_LSB +: NFLAG];

    fpx_trap_decide u_decide (
        .commit_i   (commit_i),
        .is_cmp_i   (is_cmp_i),
        .flags_i    (exc_flags_i),
        .tem_i      (tem_now),
        .xtrap_i    (xtrap_i),
        .xtype_i    (xtype_i),
        .trap_o     (trap_o),
        .rd_wr_en_o (rd_wr_en_o),
        .cause_o    (cause_o),
        .upd_o      (upd)
    );

    fpx_status_reg u_reg (
        .clk       (clk),
        .rst_n     (rst_n),
        .ld_en_i   (ld_en_i),
        .ld_data_i (ld_data_i),
        .upd_i     (upd),
        .fsr_o     (fsr_o)
    );

endmodule

// File: rtl/fpx_status_trap_chk.sv
`timescale 1ns/1ps
// fpx_status_trap_chk: temporal checks on the top-level ports.
module fpx_status_trap_chk
    import fpx_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               commit_i,
    input logic               is_cmp_i,
    input logic [NFLAG-1:0]   exc_flags_i,
    input logic               xtrap_i,
    input logic [FTT_W-1:0]   xtype_i,
    input logic               ld_en_i,
    input logic [FSR_W-1:0]   ld_data_i,
    input logic [FSR_W-1:0]   fsr_o,
    input logic               trap_o,
    input logic               rd_wr_en_o,
    input logic [CAUSE_W-1:0] cause_o
);

    AST_RESET_CLEAR: assert property (@(posedge clk) !rst_n |=> fsr_o == '0); // R1

    AST_LOAD_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        ld_en_i && !commit_i |=> fsr_o == $past(ld_data_i)); // R2

    AST_ZERO_FLAGS_NO_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
        commit_i && !xtrap_i && exc_flags_i == '0 |-> !trap_o); // R3

    AST_ACCRUE_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
        commit_i && !trap_o && !ld_en_i |=>
        (fsr_o[AEXC_LSB +: NFLAG] & $past(fsr_o[AEXC_LSB +: NFLAG])) == $past(fsr_o[AEXC_LSB +: NFLAG])); // R3

    AST_TRAP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        trap_o |-> !rd_wr_en_o); // R4

    AST_TRAP_SINGLE_CEXC: assert property (@(posedge clk) disable iff (!rst_n)
        commit_i && trap_o && !xtrap_i |=>
        $countones(fsr_o[CEXC_LSB +: NFLAG]) == 1 && fsr_o[FTT_LSB +: FTT_W] == FTT_IEEE); // R4

    AST_TRAP_AEXC_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        commit_i && trap_o && !ld_en_i |=> $stable(fsr_o[AEXC_LSB +: NFLAG])); // R4

    AST_CAUSE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !trap_o |-> cause_o == '0); // R5

    AST_CMP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        is_cmp_i |-> !rd_wr_en_o); // R6

    AST_XTRAP_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        commit_i && xtrap_i |=> fsr_o[FTT_LSB +: FTT_W] == $past(xtype_i)); // R7

    AST_XTRAP_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        commit_i && xtrap_i |-> trap_o && cause_o == '0); // R7

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !commit_i |-> !trap_o && !rd_wr_en_o); // R8

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !commit_i && !ld_en_i |=> $stable(fsr_o)); // R8

endmodule

bind fpx_status_trap fpx_status_trap_chk u_chk (.*);

// File: tb/fpx_status_trap_tb_top.sv
`timescale 1ns/1ps
// Bench: sweeps every mask x flag x compare combination, plus non-IEEE
// traps, idle cycles, coinciding load/commit and reset.
module fpx_status_trap_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        commit_i = 1'b0;
    logic        is_cmp_i = 1'b0;
    logic [4:0]  exc_flags_i = '0;
    logic        xtrap_i = 1'b0;
    logic [2:0]  xtype_i = '0;
    logic        ld_en_i = 1'b0;
    logic [31:0] ld_data_i = '0;
    logic [31:0] fsr_o;
    logic        trap_o;
    logic        rd_wr_en_o;
    logic [2:0]  cause_o;

    int          n_cmp = 0;
    int          n_bad = 0;
    logic [31:0] mdl = '0;   // expected register contents

    always #2 clk = ~clk;    // 250 MHz

    fpx_status_trap dut_i (
        .clk(clk), .rst_n(rst_n), .commit_i(commit_i), .is_cmp_i(is_cmp_i),
        .exc_flags_i(exc_flags_i), .xtrap_i(xtrap_i), .xtype_i(xtype_i),
        .ld_en_i(ld_en_i), .ld_data_i(ld_data_i), .fsr_o(fsr_o),
        .trap_o(trap_o), .rd_wr_en_o(rd_wr_en_o), .cause_o(cause_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    // One cycle: drive at a falling edge, check same-cycle outputs,
    // cross the rising edge, then check the register at the next falling edge.
    task automatic cyc(input logic ld, input logic [31:0] ldv, input logic cm,
                       input logic cp, input logic [4:0] fl, input logic xt,
                       input logic [2:0] xty, input string req);
        logic [4:0]  eff, en, oh;
        logic [2:0]  hp;
        logic        e_trap, e_wr;
        logic [2:0]  e_cause;
        logic [31:0] nxt;
        ld_en_i = ld; ld_data_i = ldv; commit_i = cm; is_cmp_i = cp;
        exc_flags_i = fl; xtrap_i = xt; xtype_i = xty;
        eff = cp ? (fl & 5'h10) : fl;
        en  = eff & mdl[27:23];
        hp  = 3'd0;
        for (int i = 0; i < 5; i++) if (en[i]) hp = 3'(i + 1);
        oh      = (hp != 0) ? 5'(5'd1 << (hp - 3'd1)) : 5'd0;
        e_trap  = cm && (xt || en != 0);
        e_cause = (cm && !xt && en != 0) ? hp : 3'd0;
        e_wr    = cm && !e_trap && !cp;
        nxt = ld ? ldv : mdl;
        if (cm) begin
            if (xt) nxt[16:14] = xty;
            else if (en != 0) begin
                nxt[4:0] = oh; nxt[16:14] = 3'd1;
            end else begin
                nxt[4:0] = eff; nxt[9:5] = nxt[9:5] | eff; nxt[16:14] = 3'd0;
            end
        end
        #1;
        chk({req, " ctl"}, {27'd0, trap_o, rd_wr_en_o, cause_o},
            {27'd0, e_trap, e_wr, e_cause});
        @(negedge clk);
        mdl = nxt;
        chk({req, " reg"}, fsr_o, mdl);
    endtask

    function automatic logic [31:0] pat(input logic [4:0] m, input int k);
        logic [31:0] v;
        v = 32'h5A3C_96E1 ^ (32'(k) * 32'h0101_0107);
        v[27:23] = m;
        return v;
    endfunction

    // Watchdog: a hung run ends as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog act=timeout exp=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int k = 0;
        repeat (3) @(negedge clk);
        chk("R1 reset", fsr_o, 32'd0);
        rst_n = 1'b1;

        // R2..R6: full sweep of mask, flags and compare.
        for (int m = 0; m < 32; m++) begin
            for (int f = 0; f < 32; f++) begin
                for (int c = 0; c < 2; c++) begin
                    logic [4:0] ef;
                    string lbl;
                    ef  = (c != 0) ? (5'(f) & 5'h10) : 5'(f);
                    lbl = (c != 0) ? "R6" : (((ef & 5'(m)) != 0) ? "R4/R5" : "R3");
                    cyc(1'b1, pat(5'(m), k), 1'b0, 1'b0, 5'h0, 1'b0, 3'd0, "R2 load");
                    cyc(1'b0, 32'd0, 1'b1, c[0], 5'(f), 1'b0, 3'd0, lbl);
                    k++;
                end
            end
        end

        // R7: non-IEEE traps override any flags.
        for (int t = 2; t < 6; t++) begin
            cyc(1'b1, pat(5'h1F, t), 1'b0, 1'b0, 5'h0, 1'b0, 3'd0, "R2 load");
            cyc(1'b0, 32'd0, 1'b1, 1'b0, 5'h1F, 1'b1, 3'(t), "R7");
            cyc(1'b0, 32'd0, 1'b1, 1'b1, 5'h00, 1'b1, 3'(t), "R7 cmp");
        end

        // R8: no commit, other inputs active.
        cyc(1'b1, pat(5'h1F, 99), 1'b0, 1'b0, 5'h0, 1'b0, 3'd0, "R2 load");
        cyc(1'b0, 32'd0, 1'b0, 1'b0, 5'h1F, 1'b1, 3'd5, "R8");
        cyc(1'b0, 32'd0, 1'b0, 1'b1, 5'h10, 1'b0, 3'd2, "R8");
        cyc(1'b0, 32'd0, 1'b0, 1'b0, 5'h0A, 1'b1, 3'd3, "R8");

        // R9: load and commit together; old mask decides.
        cyc(1'b1, pat(5'h1F, 7), 1'b0, 1'b0, 5'h0, 1'b0, 3'd0, "R2 load");
        cyc(1'b1, pat(5'h00, 8), 1'b1, 1'b0, 5'h04, 1'b0, 3'd0, "R9 trap old mask");
        cyc(1'b1, pat(5'h1F, 9), 1'b1, 1'b0, 5'h06, 1'b0, 3'd0, "R9 no trap old mask");
        cyc(1'b1, pat(5'h00, 10), 1'b1, 1'b1, 5'h1F, 1'b0, 3'd0, "R9 cmp");
        cyc(1'b1, pat(5'h00, 11), 1'b1, 1'b0, 5'h00, 1'b1, 3'd4, "R9 xtrap");

        // R1: reset in mid-run.
        rst_n = 1'b0;
        @(negedge clk);
        mdl = '0;
        chk("R1 mid-run reset", fsr_o, 32'd0);
        rst_n = 1'b1;
        cyc(1'b0, 32'd0, 1'b1, 1'b0, 5'h11, 1'b0, 3'd0, "R3 after reset");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule